// File: doc/BRIEF.md
# Flash Command Sequencer Front End

This block is the register-mapped front end of an on-chip flash controller. Software unlocks program/erase operation through a key-protected mode register. It loads a start and an end word address and, for programming, a 32-bit value split over two 16-bit write buffers. It then launches one of four operations by writing a command code with the start bit set. Each accepted operation stays busy for a fixed number of cycles and then walks its address range one word per array access. When it is finished it raises a ready flag. Software acknowledges that flag by writing zero to the control register.

Consecutive read hands words out one at a time. The block fills two 16-bit read buffers and raises a data-ready flag. Software reads the buffers and sets a read-complete bit. Clearing that bit again, with the start bit still set, asks for the next word. A forced-stop bit ends any operation early.

Error flags stay set until the next accepted start. The backing store is a small internal array whose erased state is all ones, so the block can be tested on its own. An error-injection input makes program and erase steps fail on demand.

Top module: `flash_cmd_frontend`

## Requirements
- R1: A write to the mode register (offset 0) changes bit 0 (code area enable) and bit 7 (data area enable) only when the same write carries AAh in bits 15:8. Any other write to it leaves it unchanged. Bits 15:8 always read as 00h.
- R2: Register offsets: 0 mode, 1 control, 2 start address, 3 end address, 4 write buffer low, 5 write buffer high, 6 read buffer low, 7 read buffer high, 8 status 0, 9 status 1. Reads return data one cycle after the address is presented. After reset every register reads 0000h except status 1, which reads 0004h because its bit 2 is fixed at 1.
- R3: In the control register, bits 3:0 hold the command: 0001 program, 0011 erase, 0101 consecutive read, 1011 blank check. Bit 7 is start, bit 6 forced stop and bit 4 read complete. A write with bit 7 set while idle launches the command, and the control register then reads back the written command and start bit.
- R4: A start is refused in three cases: the code is not one of the four, both mode bits are clear, or the start address is above the end address. A refused start sets status 0 bit 4 and raises ready, and it changes no array word.
- R5: Status 1 bit 6 (ready) rises when an operation ends. Writing 0000h to the control register then returns the block to idle and clears ready.
- R6: Program stores {write buffer high, write buffer low} at the start address. Ready stays low for at least BUSY_CYCLES cycles after any accepted start.
- R7: Erase sets every word from the start address through the end address to FFFFFFFFh.
- R8: Blank check sets status 0 bit 3 if any word in the range is not FFFFFFFFh, and leaves it clear otherwise.
- R9: Consecutive read sets status 1 bit 1 (data ready) once a word sits in the read buffers. Setting read complete clears data ready. Clearing it again, with start still set, fetches the next word. Ready rises after the last word is taken.
- R10: A control write with bit 6 set during an operation ends it at once with ready set and data ready clear. A stop during the busy wait leaves the array unchanged.
- R11: An accepted start clears all status 0 flags, while a refused start keeps the earlier ones. With err_inject high, a program step sets status 0 bit 1 and an erase step sets status 0 bit 0, and the affected word keeps its old value.
- R12: While an operation is active, from the start until the closing 0000h write, writes to the start/end address registers and the write buffers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the offset of the previous cycle |
| err_inject | input | 1 | Forces program and erase steps to fail |

## Verification
The situations hardest to reach are a forced stop that lands inside the busy window and a write to a locked address register in the middle of a consecutive read. The stop has to arrive before the array is touched, and the locked write has to fall between two handshake steps. The directed tasks reach both by issuing the stop on the bus write right after the start, well within the busy window. For the lock, the read is held at its first data-ready point while the address and buffer registers are written. Both effects are then checked through normal readback: a later consecutive read of the word, and reads of the address and buffer registers.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam logic [3:0] OFS_ENTRY = 4'd0;
  localparam logic [3:0] OFS_CTRL  = 4'd1;
  localparam logic [3:0] OFS_SADDR = 4'd2;
  localparam logic [3:0] OFS_EADDR = 4'd3;
  localparam logic [3:0] OFS_WBLO  = 4'd4;
  localparam logic [3:0] OFS_WBHI  = 4'd5;
  localparam logic [3:0] OFS_RBLO  = 4'd6;
  localparam logic [3:0] OFS_RBHI  = 4'd7;
  localparam logic [3:0] OFS_STAT0 = 4'd8;
  localparam logic [3:0] OFS_STAT1 = 4'd9;

  localparam logic [3:0] CMD_PROG  = 4'b0001;
  localparam logic [3:0] CMD_ERASE = 4'b0011;
  localparam logic [3:0] CMD_READ  = 4'b0101;
  localparam logic [3:0] CMD_BLANK = 4'b1011;

  localparam logic [7:0] ENTRY_KEY = 8'hAA;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_DELAY, SQ_ISSUE, SQ_EVAL, SQ_HOLD, SQ_NEXT, SQ_DONE
  } seq_state_e;

  typedef struct packed {
    logic ilgl;
    logic bc;
    logic prg;
    logic ers;
  } err_flags_t;

  function automatic logic cmd_legal(input logic [3:0] c);
    return (c == CMD_PROG) || (c == CMD_ERASE) || (c == CMD_READ) || (c == CMD_BLANK);
  endfunction
endpackage

// File: rtl/flash_fe_array.sv
module flash_fe_array #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // erased state of the backing store
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/flash_fe_regs.sv
module flash_fe_regs
  import flash_fe_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [3:0]    addr,
  input  logic [15:0]   wdata,
  input  logic          lock,
  output logic          pe_code,
  output logic          pe_data,
  output logic [AW-1:0] saddr,
  output logic [AW-1:0] eaddr,
  output logic [31:0]   wbuf
);
  logic key_ok;
  assign key_ok = (wdata[15:8] == ENTRY_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      pe_code <= 1'b0;
      pe_data <= 1'b0;
      saddr   <= '0;
      eaddr   <= '0;
      wbuf    <= '0;
    end else if (wr) begin
      if (addr == OFS_ENTRY && key_ok) begin
        pe_code <= wdata[0];
        pe_data <= wdata[7];
      end
      if (!lock) begin
        case (addr)
          OFS_SADDR: saddr <= wdata[AW-1:0];
          OFS_EADDR: eaddr <= wdata[AW-1:0];
          OFS_WBLO:  wbuf[15:0]  <= wdata;
          OFS_WBHI:  wbuf[31:16] <= wdata;
          default: ;
        endcase
      end
    end
  end

  AST_ENTRY_KEYED: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == OFS_ENTRY && wdata[15:8] != ENTRY_KEY) |=> ($stable(pe_code) && $stable(pe_data))); // R1
  AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr && lock) |=> ($stable(saddr) && $stable(eaddr) && $stable(wbuf))); // R12
endmodule

// File: rtl/flash_fe_seq.sv
module flash_fe_seq
  import flash_fe_pkg::*;
#(
  parameter int AW          = 5,
  parameter int DW          = 32,
  parameter int BUSY_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic [7:0]    ctrl_wdata,
  input  logic          pe_enabled,
  input  logic [AW-1:0] saddr,
  input  logic [AW-1:0] eaddr,
  input  logic [DW-1:0] wbuf,
  input  logic          err_inject,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          active,
  output logic          frdy,
  output logic          drrdy,
  output err_flags_t    errs,
  output logic [7:0]    ctrl_rd,
  output logic [DW-1:0] rbuf
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUSY_CYCLES - 1);

  seq_state_e     state;
  logic [3:0]     cmd_q;
  logic           opst_q;
  logic           drc_q;
  logic [AW-1:0]  cur;
  logic [CNT_W-1:0] cnt;

  logic start_req, stop_req, in_flight, refuse, last_word;

  assign start_req = ctrl_wr && ctrl_wdata[7];
  assign stop_req  = ctrl_wr && ctrl_wdata[6];
  assign in_flight = (state != SQ_IDLE) && (state != SQ_DONE);
  assign refuse    = !cmd_legal(ctrl_wdata[3:0]) || !pe_enabled || (saddr > eaddr);
  assign last_word = (cur == eaddr);

  assign active  = (state != SQ_IDLE);
  assign frdy    = (state == SQ_DONE);
  assign ctrl_rd = {opst_q, 2'b00, drc_q, cmd_q};

  always_comb begin
    mem_addr  = cur;
    mem_we    = (state == SQ_ISSUE) && !err_inject && !stop_req &&
                ((cmd_q == CMD_PROG) || (cmd_q == CMD_ERASE));
    mem_wdata = (cmd_q == CMD_PROG) ? wbuf : '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      cmd_q  <= '0;
      opst_q <= 1'b0;
      drc_q  <= 1'b0;
      cur    <= '0;
      cnt    <= '0;
      errs   <= '0;
      drrdy  <= 1'b0;
      rbuf   <= '0;
    end else if (stop_req && in_flight) begin
      state <= SQ_DONE;
      drrdy <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (ctrl_wr) begin
          cmd_q  <= ctrl_wdata[3:0];
          drc_q  <= ctrl_wdata[4];
          opst_q <= ctrl_wdata[7];
          if (start_req) begin
            if (refuse) begin
              errs.ilgl <= 1'b1;
              state     <= SQ_DONE;
            end else begin
              errs  <= '0;
              cur   <= saddr;
              cnt   <= '0;
              state <= SQ_DELAY;
            end
          end
        end
        SQ_DELAY: begin
          if (cnt == CNT_LAST) state <= SQ_ISSUE;
          else                 cnt   <= cnt + 1'b1;
        end
        SQ_ISSUE: begin
          case (cmd_q)
            CMD_PROG: begin
              if (err_inject) errs.prg <= 1'b1;
              state <= SQ_DONE;
            end
            CMD_ERASE: begin
              if (err_inject) errs.ers <= 1'b1;
              if (last_word) state <= SQ_DONE;
              else           cur   <= cur + 1'b1;
            end
            default: state <= SQ_EVAL;
          endcase
        end
        SQ_EVAL: begin
          if (cmd_q == CMD_READ) begin
            rbuf  <= mem_rdata;
            drrdy <= 1'b1;
            state <= SQ_HOLD;
          end else begin
            if (mem_rdata != '1) errs.bc <= 1'b1;
            if (last_word) state <= SQ_DONE;
            else begin
              cur   <= cur + 1'b1;
              state <= SQ_ISSUE;
            end
          end
        end
        SQ_HOLD: if (ctrl_wr && ctrl_wdata[4]) begin
          drc_q <= 1'b1;
          drrdy <= 1'b0;
          state <= last_word ? SQ_DONE : SQ_NEXT;
        end
        SQ_NEXT: if (ctrl_wr && ctrl_wdata[7] && !ctrl_wdata[4]) begin
          drc_q <= 1'b0;
          cur   <= cur + 1'b1;
          state <= SQ_ISSUE;
        end
        SQ_DONE: if (ctrl_wr && ctrl_wdata == 8'h00) begin
          opst_q <= 1'b0;
          cmd_q  <= '0;
          drc_q  <= 1'b0;
          state  <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_REFUSED_CODE: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE && start_req && !cmd_legal(ctrl_wdata[3:0])) |=> (frdy && errs.ilgl)); // R4
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE && start_req && !refuse) |=> (errs == '0 && !frdy)); // R11
  AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_DONE && ctrl_wr && ctrl_wdata == 8'h00) |=> (!frdy && !active)); // R5
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (stop_req && in_flight) |=> (frdy && !drrdy)); // R10
  AST_DRRDY_READ: assert property (@(posedge clk) disable iff (rst)
    drrdy |-> (cmd_q == CMD_READ && !frdy)); // R9
  AST_DELAY_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_DELAY) |-> (cnt <= CNT_LAST)); // R6
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int BUSY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        err_inject
);
  localparam int DW  = 32;
  localparam int PAD = 16 - ADDR_W;

  logic          pe_code, pe_data, active, frdy, drrdy;
  logic [ADDR_W-1:0] saddr, eaddr, mem_addr;
  logic [DW-1:0] wbuf, rbuf, mem_wdata, mem_rdata;
  logic          mem_we;
  logic [7:0]    ctrl_rd;
  err_flags_t    errs;

  flash_fe_regs #(.AW(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .lock(active), .pe_code(pe_code), .pe_data(pe_data),
    .saddr(saddr), .eaddr(eaddr), .wbuf(wbuf)
  );

  flash_fe_seq #(.AW(ADDR_W), .DW(DW), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst(rst),
    .ctrl_wr(bus_wr && bus_addr == OFS_CTRL), .ctrl_wdata(bus_wdata[7:0]),
    .pe_enabled(pe_code || pe_data), .saddr(saddr), .eaddr(eaddr), .wbuf(wbuf),
    .err_inject(err_inject), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .active(active),
    .frdy(frdy), .drrdy(drrdy), .errs(errs), .ctrl_rd(ctrl_rd), .rbuf(rbuf)
  );

  flash_fe_array #(.AW(ADDR_W), .DW(DW)) u_array (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        OFS_ENTRY: bus_rdata <= {8'h00, pe_data, 6'b0, pe_code};
        OFS_CTRL:  bus_rdata <= {8'h00, ctrl_rd};
        OFS_SADDR: bus_rdata <= {{PAD{1'b0}}, saddr};
        OFS_EADDR: bus_rdata <= {{PAD{1'b0}}, eaddr};
        OFS_WBLO:  bus_rdata <= wbuf[15:0];
        OFS_WBHI:  bus_rdata <= wbuf[31:16];
        OFS_RBLO:  bus_rdata <= rbuf[15:0];
        OFS_RBHI:  bus_rdata <= rbuf[31:16];
        OFS_STAT0: bus_rdata <= {11'b0, errs.ilgl, errs.bc, 1'b0, errs.prg, errs.ers};
        OFS_STAT1: bus_rdata <= {8'h00, 1'b0, frdy, 3'b000, 1'b1, drrdy, 1'b0};
        default:   bus_rdata <= '0;
      endcase
    end
  end

  AST_STAT1_FIXED: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == OFS_STAT1 && !$past(rst)) |-> (bus_rdata[2] && bus_rdata[15:8] == 8'h00)); // R2
endmodule

// File: tb/tb_flash_cmd_frontend.sv
module tb_flash_cmd_frontend;
  import flash_fe_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        err_inject = 1'b0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_frontend #(.ADDR_W(5), .BUSY_CYCLES(8)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_inject(err_inject)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_stat1(input int bitpos, input string req);
    logic [15:0] v;
    bit seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      rd(OFS_STAT1, v);
      if (v[bitpos]) seen = 1;
    end
    check(req, "flag wait", {31'b0, seen}, 32'd1);
  endtask

  task automatic set_range(input logic [15:0] sa, input logic [15:0] ea);
    wr(OFS_SADDR, sa);
    wr(OFS_EADDR, ea);
  endtask

  task automatic run_cmd(input logic [7:0] code, input string req, input logic [15:0] exp_stat0);
    logic [15:0] v;
    wr(OFS_CTRL, {8'h00, code});
    wait_stat1(6, req);
    rd(OFS_STAT0, v);
    check(req, "status 0 after command", {16'h0, v}, {16'h0, exp_stat0});
    wr(OFS_CTRL, 16'h0000);
  endtask

  task automatic read_word(input logic [15:0] a, output logic [31:0] w);
    logic [15:0] lo, hi;
    set_range(a, a);
    wr(OFS_CTRL, 16'h0085);
    wait_stat1(1, "R9");
    rd(OFS_RBLO, lo);
    rd(OFS_RBHI, hi);
    wr(OFS_CTRL, 16'h0095);
    wait_stat1(6, "R9");
    wr(OFS_CTRL, 16'h0000);
    w = {hi, lo};
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(OFS_STAT1, v); check("R2", "status 1 reset", {16'h0, v}, 32'h0004);
    rd(OFS_STAT0, v); check("R2", "status 0 reset", {16'h0, v}, 32'h0000);
    rd(OFS_ENTRY, v); check("R2", "mode reset", {16'h0, v}, 32'h0000);
    rd(OFS_CTRL, v);  check("R2", "control reset", {16'h0, v}, 32'h0000);
  endtask

  task automatic t_refuse_no_entry();
    logic [15:0] v;
    set_range(16'd0, 16'd0);
    wr(OFS_CTRL, 16'h0081);
    rd(OFS_STAT0, v); check("R4", "start without mode bit", {16'h0, v}, 32'h0010);
    rd(OFS_STAT1, v); check("R4", "ready after refusal", {16'h0, v}, 32'h0044);
    wr(OFS_CTRL, 16'h0000);
    rd(OFS_STAT1, v); check("R5", "ready cleared by 0000h", {16'h0, v}, 32'h0004);
  endtask

  task automatic t_entry();
    logic [15:0] v;
    wr(OFS_ENTRY, 16'h0081);
    rd(OFS_ENTRY, v); check("R1", "keyless write ignored", {16'h0, v}, 32'h0000);
    wr(OFS_ENTRY, 16'hAA81);
    rd(OFS_ENTRY, v); check("R1", "keyed write, upper reads 00h", {16'h0, v}, 32'h0081);
    wr(OFS_ENTRY, 16'h5500);
    rd(OFS_ENTRY, v); check("R1", "wrong key ignored", {16'h0, v}, 32'h0081);
    wr(OFS_ENTRY, 16'hAA01);
    rd(OFS_ENTRY, v); check("R1", "code bit only", {16'h0, v}, 32'h0001);
  endtask

  task automatic t_refuse_cases();
    logic [15:0] v;
    set_range(16'd2, 16'd2);
    run_cmd(8'h87, "R4", 16'h0010);
    set_range(16'd5, 16'd2);
    wr(OFS_CTRL, 16'h0081);
    rd(OFS_STAT0, v); check("R4", "start above end refused", {16'h0, v}, 32'h0010);
    wr(OFS_CTRL, 16'h0000);
  endtask

  task automatic t_program();
    logic [15:0] v;
    logic [31:0] w;
    set_range(16'd3, 16'd3);
    wr(OFS_WBLO, 16'h1234);
    wr(OFS_WBHI, 16'hABCD);
    wr(OFS_CTRL, 16'h0081);
    rd(OFS_STAT1, v); check("R6", "busy right after start", {16'h0, v}, 32'h0004);
    rd(OFS_STAT0, v); check("R11", "accepted start clears flags", {16'h0, v}, 32'h0000);
    wait_stat1(6, "R5");
    rd(OFS_CTRL, v); check("R3", "control readback", {16'h0, v}, 32'h0081);
    wr(OFS_CTRL, 16'h0000);
    read_word(16'd3, w); check("R6", "programmed word 3", w, 32'hABCD1234);
    set_range(16'd4, 16'd4);
    wr(OFS_WBLO, 16'h0F0F);
    wr(OFS_WBHI, 16'h00FF);
    run_cmd(8'h81, "R3", 16'h0000);
  endtask

  task automatic t_consec_read();
    logic [15:0] v, lo, hi;
    set_range(16'd3, 16'd4);
    wr(OFS_CTRL, 16'h0085);
    wait_stat1(1, "R9");
    rd(OFS_STAT1, v); check("R9", "data ready set", {16'h0, v}, 32'h0006);
    rd(OFS_RBLO, lo); rd(OFS_RBHI, hi);
    check("R9", "first word", {hi, lo}, 32'hABCD1234);
    wr(OFS_CTRL, 16'h0095);
    rd(OFS_STAT1, v); check("R9", "data ready cleared, not done", {16'h0, v}, 32'h0004);
    wr(OFS_CTRL, 16'h0085);
    wait_stat1(1, "R9");
    rd(OFS_RBLO, lo); rd(OFS_RBHI, hi);
    check("R9", "second word", {hi, lo}, 32'h00FF0F0F);
    wr(OFS_CTRL, 16'h0095);
    wait_stat1(6, "R9");
    wr(OFS_CTRL, 16'h0000);
  endtask

  task automatic t_blank_erase();
    logic [31:0] w;
    set_range(16'd3, 16'd4);
    run_cmd(8'h8B, "R8", 16'h0008);
    set_range(16'd10, 16'd12);
    run_cmd(8'h8B, "R8", 16'h0000);
    set_range(16'd3, 16'd4);
    run_cmd(8'h83, "R7", 16'h0000);
    read_word(16'd3, w); check("R7", "word 3 erased", w, 32'hFFFFFFFF);
    read_word(16'd4, w); check("R7", "word 4 erased", w, 32'hFFFFFFFF);
    set_range(16'd3, 16'd4);
    run_cmd(8'h8B, "R8", 16'h0000);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    logic [31:0] w;
    set_range(16'd6, 16'd6);
    wr(OFS_WBLO, 16'h5555);
    wr(OFS_WBHI, 16'hAAAA);
    wr(OFS_CTRL, 16'h0081);
    wr(OFS_CTRL, 16'h0040);
    rd(OFS_STAT1, v); check("R10", "ready after stop", {16'h0, v}, 32'h0044);
    wr(OFS_CTRL, 16'h0000);
    read_word(16'd6, w); check("R10", "stopped program left word", w, 32'hFFFFFFFF);
  endtask

  task automatic t_inject();
    logic [31:0] w;
    set_range(16'd7, 16'd7);
    wr(OFS_WBLO, 16'h0000);
    wr(OFS_WBHI, 16'h0000);
    err_inject = 1'b1;
    run_cmd(8'h81, "R11", 16'h0002);
    err_inject = 1'b0;
    run_cmd(8'h87, "R11", 16'h0012);
    read_word(16'd7, w); check("R11", "failed program left word", w, 32'hFFFFFFFF);
    set_range(16'd8, 16'd8);
    wr(OFS_WBLO, 16'h5678);
    wr(OFS_WBHI, 16'h1234);
    run_cmd(8'h81, "R11", 16'h0000);
    err_inject = 1'b1;
    run_cmd(8'h83, "R11", 16'h0001);
    err_inject = 1'b0;
    read_word(16'd8, w); check("R11", "failed erase left word", w, 32'h12345678);
  endtask

  task automatic t_lock();
    logic [15:0] v, wb_before;
    rd(OFS_WBLO, wb_before);
    set_range(16'd0, 16'd1);
    wr(OFS_CTRL, 16'h0085);
    wait_stat1(1, "R12");
    wr(OFS_SADDR, 16'd9);
    wr(OFS_WBLO, 16'h7777);
    rd(OFS_SADDR, v); check("R12", "start address locked", {16'h0, v}, 32'h0000);
    rd(OFS_WBLO, v);  check("R12", "write buffer locked", {16'h0, v}, {16'h0, wb_before});
    wr(OFS_CTRL, 16'h0040);
    rd(OFS_STAT1, v); check("R10", "stop during read", {16'h0, v}, 32'h0044);
    wr(OFS_CTRL, 16'h0000);
    wr(OFS_SADDR, 16'd9);
    rd(OFS_SADDR, v); check("R12", "start address writable when idle", {16'h0, v}, 32'h0009);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_refuse_no_entry();
    t_entry();
    t_refuse_cases();
    t_program();
    t_consec_read();
    t_blank_erase();
    t_stop();
    t_inject();
    t_lock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule